// File: doc/BRIEF.md
# PLL Lock Retry Sequencer

This controller brings a display clock PLL from "configured" to "locked and usable" once software or a setup engine has written the PLL's divider settings. A start request makes it issue a one-cycle GO command to the PLL. It then leaves one quiet cycle for the command to land, counts a fixed number of reference-clock enable ticks, and makes a single judgement on the PLL status word and on the PLL's GO-pending flag.

A lock is accepted only when the whole healthy status pattern is present: locked and out of reset, with no bypass, no jitter alarm, no lost reference and no recalibration in progress. GO must also have self-cleared. A failed judgement re-issues GO, up to a fixed number of attempts. The block ends with done or error. Either flag stays up until the next start, and the number of attempts used stays readable on the retry count output.

Top module: `pll_lock_seq`

## Requirements
- R1: Each attempt begins with `go_cmd` high for exactly one clock cycle. The first pulse appears in the cycle after an accepted `start`. `retry_count` counts the pulses issued since that `start`.
- R2: After each GO pulse and one further ignored cycle, the block waits for exactly WAIT_TICKS cycles in which `ref_tick` is high (default 1000) and then evaluates. Ticks in the pulse cycle and in the ignored cycle are not counted, and status is never evaluated earlier.
- R3: The status check passes only when `pll_status` bit 0 = 1 (reset complete), bit 1 = 1 (locked), bit 2 = 0 (recalibrating), bit 3 = 0 (reference lost), bit 5 = 0 (jitter alarm) and bit 6 = 0 (bypassed), i.e. `(pll_status & 7'h6F) == 7'h03`. Bit 4 has no effect.
- R4: An attempt fails if `go_pending` is high at evaluation time, even when the status pattern matches.
- R5: On the first passing attempt the block stops issuing GO, raises `done`, and `retry_count` holds that attempt's number (1-based).
- R6: After MAX_TRIES failed attempts (default 20) the block raises `error`, issues no further GO, and `retry_count` equals MAX_TRIES. `retry_count` never exceeds MAX_TRIES.
- R7: `done` and `error` are never high together. Each stays high until the next accepted `start`, which clears both.
- R8: `start` has no effect while `busy` is high.
- R9: While `rst_n` is low at a clock edge, the block returns to idle with `go_cmd`, `busy`, `done`, `error` low and `retry_count` zero.
- R10: `busy` is high from the cycle after an accepted `start` until the cycle in which `done` or `error` rises, and is low whenever `done` or `error` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a lock sequence (accepted only when idle) |
| ref_tick | input | 1 | One-cycle enable marking one reference-clock period |
| go_pending | input | 1 | PLL reports the GO command still in progress |
| pll_status | input | STAT_W (7) | PLL status word |
| go_cmd | output | 1 | One-cycle GO command to the PLL |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Lock achieved; held until next start |
| error | output | 1 | All attempts failed; held until next start |
| retry_count | output | TRY_W (5) | Attempts issued since the last start |

## Verification
The bench drives status words that are fully healthy, healthy with the ignored bit 4 set, and wrong in exactly one checked bit at a time. These show whether each checked bit is judged at its own position and whether bit 4 is excluded. A healthy word paired with GO still pending separates the GO-pending gate from the status gate. Runs that succeed on the last allowed attempt, and runs that fail on every attempt, separate an off-by-one in the attempt limit from a correct stop. Random per-attempt status, random GO-pending values and a random tick density check that exactly the configured number of ticks separates every GO from its judgement, and that a start pulse in mid-run restarts nothing.

// File: rtl/pll_lock_pkg.sv
// Package: pll_lock_pkg
// Shared types for the PLL lock retry sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package pll_lock_pkg;

    // Sequencer phases: idle, GO pulse, flush gap, tick wait
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PULSE = 2'd1,
        S_FLUSH = 2'd2,
        S_WAIT  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/pll_stat_eval.sv
// Module: pll_stat_eval
// Judges one lock attempt from the PLL status word and the GO-pending flag.
// Assumes: STAT_W >= 7. Bits 0,1 must be set; bits 2,3,5,6 clear; bit 4 and
// any bits above 6 are don't-care.
module pll_stat_eval #(
    parameter int STAT_W = 7
) (
    input  logic [STAT_W-1:0] status,
    input  logic              go_pending,
    output logic              healthy
);

    localparam logic [STAT_W-1:0] CARE_MASK = STAT_W'(7'h6F);
    localparam logic [STAT_W-1:0] GOOD_VAL  = STAT_W'(7'h03);

    // Pattern match on the checked bits, gated by GO having self-cleared
    always_comb begin
        healthy = ((status & CARE_MASK) == GOOD_VAL) && !go_pending;
    end

endmodule

// File: rtl/pll_tick_timer.sv
// Module: pll_tick_timer
// Counts reference-clock enable ticks and flags the tick that completes the
// wait window.
// Assumes: clear and advance are never needed in the same cycle; WAIT_TICKS >= 1.
module pll_tick_timer #(
    parameter int WAIT_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic expire
);

    localparam int WAIT_W = $clog2(WAIT_TICKS > 1 ? WAIT_TICKS : 2);
    localparam logic [WAIT_W-1:0] LAST_IDX = WAIT_W'(WAIT_TICKS - 1);

    logic [WAIT_W-1:0] tick_cnt;

    // Tick counter: cleared at the start of each window, steps per tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (clear) begin
            tick_cnt <= '0;
        end else if (advance && tick_cnt != LAST_IDX) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    // Window completes on the tick that finds the counter at its last index
    always_comb begin
        expire = advance && (tick_cnt == LAST_IDX);
    end

endmodule

// File: rtl/pll_try_counter.sv
// Module: pll_try_counter
// Counts GO attempts since the last start and flags the attempt limit.
// Assumes: MAX_TRIES >= 1; incr is issued once per GO pulse.
module pll_try_counter #(
    parameter int MAX_TRIES = 20,
    parameter int TRY_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             incr,
    output logic [TRY_W-1:0] count,
    output logic             at_limit
);

    localparam logic [TRY_W-1:0] LIMIT = TRY_W'(MAX_TRIES);

    // Attempt counter: saturates at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (incr && count != LIMIT) begin
            count <= count + 1'b1;
        end
    end

    // Limit flag used by the sequencer after a failed judgement
    always_comb begin
        at_limit = (count == LIMIT);
    end

endmodule

// File: rtl/pll_lock_seq.sv
// Module: pll_lock_seq (top)
// Issues GO to a display PLL, waits a fixed number of reference ticks, judges
// status and GO-pending, and retries up to MAX_TRIES times. It reports done or
// error, each held until the next start.
// Assumes: ref_tick is synchronous to clk; pll_status and go_pending are
// already synchronised to clk.
module pll_lock_seq #(
    parameter int WAIT_TICKS = 1000,
    parameter int MAX_TRIES  = 20,
    parameter int STAT_W     = 7,
    parameter int TRY_W      = $clog2(MAX_TRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ref_tick,
    input  logic              go_pending,
    input  logic [STAT_W-1:0] pll_status,
    output logic              go_cmd,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [TRY_W-1:0]  retry_count
);

    import pll_lock_pkg::*;

    seq_state_t state;
    logic       healthy;
    logic       expire;
    logic       at_limit;
    logic       try_clear;
    logic       try_incr;
    logic       tmr_clear;
    logic       tmr_adv;

    // Attempt judgement
    pll_stat_eval #(.STAT_W(STAT_W)) u_eval (
        .status     (pll_status),
        .go_pending (go_pending),
        .healthy    (healthy)
    );

    // Reference-tick wait window
    pll_tick_timer #(.WAIT_TICKS(WAIT_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .advance (tmr_adv),
        .expire  (expire)
    );

    // Attempt count and limit
    pll_try_counter #(.MAX_TRIES(MAX_TRIES), .TRY_W(TRY_W)) u_tries (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (try_clear),
        .incr     (try_incr),
        .count    (retry_count),
        .at_limit (at_limit)
    );

    // Control strobes decoded from the current phase
    always_comb begin
        go_cmd    = (state == S_PULSE);
        busy      = (state != S_IDLE);
        try_clear = (state == S_IDLE) && start;
        try_incr  = (state == S_PULSE);
        tmr_clear = (state == S_FLUSH);
        tmr_adv   = (state == S_WAIT) && ref_tick;
    end

    // Phase sequencing and outcome flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            done  <= 1'b0;
            error <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        state <= S_PULSE;
                        done  <= 1'b0;
                        error <= 1'b0;
                    end
                end
                S_PULSE: state <= S_FLUSH;
                S_FLUSH: state <= S_WAIT;
                S_WAIT: begin
                    if (expire) begin
                        if (healthy) begin
                            state <= S_IDLE;
                            done  <= 1'b1;
                        end else if (at_limit) begin
                            state <= S_IDLE;
                            error <= 1'b1;
                        end else begin
                            state <= S_PULSE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pll_lock_seq_chk.sv
// Module: pll_lock_seq_chk
// Port-level properties of the lock sequencer, bound onto every instance.
// Assumes: it observes the top-level ports only.
module pll_lock_seq_chk #(
    parameter int MAX_TRIES = 20,
    parameter int TRY_W     = $clog2(MAX_TRIES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             go_cmd,
    input logic             busy,
    input logic             done,
    input logic             error,
    input logic [TRY_W-1:0] retry_count
);

    // R1: GO is a single-cycle pulse
    p_go_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        go_cmd |=> !go_cmd);

    // R1: an accepted start produces GO in the next cycle
    p_go_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> go_cmd);

    // R6: attempt count stays within the limit
    p_count_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        retry_count <= TRY_W'(MAX_TRIES));

    // R6: no GO outside a running sequence
    p_go_only_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        go_cmd |-> busy);

    // R7: outcomes are exclusive
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    // R7: done holds until a start
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R7: error holds until a start
    p_error_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

    // R10: an outcome is only shown while idle
    p_outcome_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> !busy);

endmodule

bind pll_lock_seq pll_lock_seq_chk #(
    .MAX_TRIES (MAX_TRIES),
    .TRY_W     (TRY_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .go_cmd      (go_cmd),
    .busy        (busy),
    .done        (done),
    .error       (error),
    .retry_count (retry_count)
);

// File: tb/pll_lock_seq_tb.sv
`timescale 1ns/1ps
module pll_lock_seq_tb_top;

    localparam int WAIT_TICKS = 1000;
    localparam int MAX_TRIES  = 20;
    localparam int STAT_W     = 7;
    localparam int TRY_W      = $clog2(MAX_TRIES + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              ref_tick = 1'b0;
    logic              go_pending = 1'b0;
    logic [STAT_W-1:0] pll_status = '0;
    logic              go_cmd, busy, done, error;
    logic [TRY_W-1:0]  retry_count;

    int checks = 0;
    int errors = 0;

    logic [6:0] plan_stat [MAX_TRIES];
    logic       plan_gp   [MAX_TRIES];

    always #2.5 clk = ~clk;

    pll_lock_seq #(
        .WAIT_TICKS (WAIT_TICKS),
        .MAX_TRIES  (MAX_TRIES),
        .STAT_W     (STAT_W)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .ref_tick    (ref_tick),
        .go_pending  (go_pending),
        .pll_status  (pll_status),
        .go_cmd      (go_cmd),
        .busy        (busy),
        .done        (done),
        .error       (error),
        .retry_count (retry_count)
    );

    // Compare and report one value
    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Model of the lock criterion (R3, R4)
    function automatic bit attempt_ok(input logic [6:0] s, input logic gp);
        return ((s & 7'h6F) == 7'h03) && !gp;
    endfunction

    // Expected attempt number of the first pass, 0 when all fail (R5, R6)
    function automatic int exp_pass();
        for (int i = 0; i < MAX_TRIES; i++)
            if (attempt_ok(plan_stat[i], plan_gp[i])) return i + 1;
        return 0;
    endfunction

    // One full sequence; poke_at >= 0 pulses start that many cycles in (R8)
    task automatic do_run(input string tag, input int poke_at);
        int  exp_n, gos, tcount, n;
        bit  fl, prev_go;
        exp_n = exp_pass();
        @(negedge clk);
        start = 1'b1;
        ref_tick = ($urandom % 4) != 0;
        @(negedge clk);
        start = 1'b0;
        chk("R10", {tag, " busy after start"}, int'(busy), 1);
        chk("R7", {tag, " outcome cleared by start"}, int'(done | error), 0);
        gos = 0; tcount = 0; fl = 1'b0; prev_go = 1'b0; n = 0;
        forever begin
            ref_tick = ($urandom % 4) != 0;
            if (!busy) break;
            if (go_cmd) begin
                if (prev_go) chk("R1", {tag, " GO longer than one cycle"}, 1, 0);
                if (gos > 0) chk("R2", {tag, " ticks before retry"}, tcount, WAIT_TICKS);
                if (gos < MAX_TRIES) begin
                    pll_status = plan_stat[gos];
                    go_pending = plan_gp[gos];
                end
                gos++;
                tcount = 0;
                fl = 1'b1;
            end else if (fl) begin
                fl = 1'b0;
            end else if (ref_tick) begin
                tcount++;
            end
            prev_go = go_cmd;
            start = (n == poke_at);
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        chk("R2", {tag, " ticks before final judgement"}, tcount, WAIT_TICKS);
        chk("R1", {tag, " GO pulses"}, gos, exp_n == 0 ? MAX_TRIES : exp_n);
        if (exp_n == 0) begin
            chk("R6", {tag, " error"}, int'(error), 1);
            chk("R6", {tag, " retry_count at limit"}, int'(retry_count), MAX_TRIES);
        end else begin
            chk("R5", {tag, " done"}, int'(done), 1);
            chk("R5", {tag, " retry_count"}, int'(retry_count), exp_n);
        end
        chk("R7", {tag, " not both outcomes"}, int'(done & error), 0);
        repeat (5) @(negedge clk);
        chk("R7", {tag, " outcome held"}, int'(done ? 1 : (error ? 2 : 0)),
            exp_n == 0 ? 2 : 1);
        chk("R6", {tag, " no GO after finish"}, int'(go_cmd | busy), 0);
    endtask

    task automatic fill_plan(input logic [6:0] s, input logic gp);
        for (int i = 0; i < MAX_TRIES; i++) begin
            plan_stat[i] = s;
            plan_gp[i]   = gp;
        end
    endtask

    task automatic check_idle_reset(input string tag);
        chk("R9", {tag, " go_cmd"}, int'(go_cmd), 0);
        chk("R9", {tag, " busy"}, int'(busy), 0);
        chk("R9", {tag, " done/error"}, int'(done | error), 0);
        chk("R9", {tag, " retry_count"}, int'(retry_count), 0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam logic [6:0] BAD_ONE [6] = '{7'h43, 7'h23, 7'h0B, 7'h07, 7'h01, 7'h02};

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check_idle_reset("R9 initial reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R3: bit 4 set on an otherwise healthy word still passes at once
        fill_plan(7'h01, 1'b0);
        plan_stat[0] = 7'h13;
        do_run("R3 bit4 ignored", -1);

        // R3: each checked bit wrong on its own fails; healthy on attempt 7
        fill_plan(7'h01, 1'b0);
        for (int i = 0; i < 6; i++) plan_stat[i] = BAD_ONE[i];
        plan_stat[6] = 7'h03;
        do_run("R3 single-bit faults", -1);

        // R4: healthy status with GO pending fails; R8: mid-run start ignored
        fill_plan(7'h01, 1'b0);
        plan_stat[0] = 7'h03; plan_gp[0] = 1'b1;
        plan_stat[1] = 7'h13; plan_gp[1] = 1'b0;
        do_run("R4 R8 go pending, poke start", 700);

        // R5: pass on the last allowed attempt
        fill_plan(7'h03, 1'b1);
        plan_gp[MAX_TRIES-1] = 1'b0;
        do_run("R5 last attempt passes", -1);

        // R6: every attempt fails, with a start poke during the run (R8)
        fill_plan(7'h03, 1'b0);
        for (int i = 0; i < MAX_TRIES; i++) plan_stat[i] = BAD_ONE[i % 6];
        do_run("R6 R8 all attempts fail", 3000);

        // R9: reset in the middle of a run
        fill_plan(7'h01, 1'b0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle_reset("R9 mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);

        // Random per-attempt plans, biased towards early success
        for (int r = 0; r < 14; r++) begin
            for (int i = 0; i < MAX_TRIES; i++) begin
                if (($urandom % 5) < 2) plan_stat[i] = 7'h03 | (($urandom % 2) ? 7'h10 : 7'h00);
                else plan_stat[i] = 7'($urandom % 128);
                plan_gp[i] = ($urandom % 4) == 0;
            end
            plan_stat[6] = 7'h03; plan_gp[6] = 1'b0;
            do_run($sformatf("R3 R4 R5 random run %0d", r), (r % 3 == 0) ? 40 : -1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule